// File: doc/BRIEF.md
# Two-Level Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of n-bit saturating up/down counters. One counter is picked by mixing a few address bits of the branch with a shift register of recent branch outcomes, so the same branch can carry different predictions depending on the path that led to it. Fetch logic presents a program counter on the lookup side and receives a taken or not-taken guess in the same cycle. When the branch later resolves, the execution stage presents its PC and real direction on the update side. That update adjusts the counter that was chosen and shifts the outcome into the history.

Elaboration parameters choose the variant. With `HIST_SEL_BITS` = 0, all branches share one history register. With `HIST_SEL_BITS` = a > 0, there are 2^a history registers, and word address bits PC[a+1:2] pick one of them. Pattern-table index bits are always taken from the word address. The low two PC bits are never used. With `HASH_IDX` = 0, the index is the concatenation {PC[M+1:2], history}. With `HASH_IDX` = 1, the index is PC[M+K+1:2] XOR the zero-extended history.

Each counter is a small state machine with four named regions: strong not-taken (0), weak not-taken (2^(n-1)-1), weak taken (2^(n-1)) and strong taken (2^n-1). Three transitions act on a counter. CTR_HOLD applies when the entry is not the one being updated. CTR_INC applies on a taken outcome and stops at strong taken. CTR_DEC applies on a not-taken outcome and stops at strong not-taken. Each history register moves in a single transition: a resolved branch shifts its outcome in at the least significant bit.

Top module: `bp_corr_predictor`

## Requirements
- R1: After reset, every counter holds weak not-taken (2^(n-1)-1) and every history register is zero, so every lookup predicts not-taken (`lk_taken` = 0).
- R2: `lk_taken` is 1 exactly when the selected counter is at least 2^(n-1). With the default 2-bit counters, a single taken update from reset makes that entry predict taken.
- R3: On an update, the selected counter moves up by one for taken (`upd_taken` = 1) and down by one for not-taken. It saturates at 2^n-1 and at 0, so from strong taken one not-taken update still predicts taken, and from 0 a further not-taken update leaves it at 0.
- R4: On each update, the selected K-bit history register becomes {old[K-2:0], upd_taken}. Only the last K outcomes are kept.
- R5: Only the counter chosen by the update PC and history changes. No counter and no history changes in a cycle without `upd_valid`.
- R6: With `HIST_SEL_BITS` = 0, one history register is shared: an update at any PC changes the history used by lookups at every PC.
- R7: With `HIST_SEL_BITS` = a > 0, the history register is chosen by PC[a+1:2]. An update only changes the history seen by PCs with the same value in those bits.
- R8: With `HASH_IDX` = 0, the table index is {PC[M+1:2], history}. PC bits above M+1 and PC[1:0] do not affect it.
- R9: With `HASH_IDX` = 1, the table index is PC[M+K+1:2] XOR the zero-extended history.
- R10: A lookup in the same cycle as an update sees the table and history from before that update. The update takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC presented for a prediction |
| lk_taken | output | 1 | Prediction for `lk_pc`, 1 = taken (combinational) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The properties assume that `upd_valid`, `upd_pc` and `upd_taken` are steady around each rising edge. They also assume at least two history bits, so that the shift pattern is meaningful. The bench holds the update strobe high for exactly one edge per resolved branch. It changes inputs only a nanosecond after an edge and samples the combinational prediction a few nanoseconds later. Lookup and update PCs are always word-aligned, except where a test deliberately sets the low bits to show that they are ignored. Three parameter sets run side by side on shared inputs, with a reset before each directed section, so that every expected value starts from the reset state.

// File: rtl/bp_corr_pkg.sv
package bp_corr_pkg;

    // Per-counter transition chosen for one clock.
    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_INC  = 2'd1,
        CTR_DEC  = 2'd2
    } ctr_act_e;

    // Bits of the PC that never take part in indexing (word alignment).
    localparam int unsigned PC_ALIGN_BITS = 2;

endpackage

// File: rtl/bp_hist_file.sv
module bp_hist_file #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned K     = 2,
    parameter int unsigned A     = 0,
    localparam int unsigned HREGS = 1 << A,
    localparam int unsigned SEL_W = (A > 0) ? A : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PC_W-1:0]     lk_pc,
    input  logic                upd_valid,
    input  logic [PC_W-1:0]     upd_pc,
    input  logic                upd_taken,
    output logic [K-1:0]        lk_hist,
    output logic [K-1:0]        upd_hist,
    output logic [SEL_W-1:0]    upd_sel,
    output logic [HREGS*K-1:0]  hist_vec
);
    import bp_corr_pkg::*;

    logic [K-1:0] hist_q [HREGS];
    logic [K-1:0] hist_shifted;

    generate
        if (A == 0) begin : g_global
            // One register shared by every branch.
            assign lk_hist  = hist_q[0];
            assign upd_hist = hist_q[0];
            assign upd_sel  = '0;
        end else begin : g_per_addr
            logic [A-1:0] lk_sel;
            assign lk_sel   = lk_pc[PC_ALIGN_BITS +: A];
            assign upd_sel  = upd_pc[PC_ALIGN_BITS +: A];
            assign lk_hist  = hist_q[lk_sel];
            assign upd_hist = hist_q[upd_sel];
        end
    endgenerate

    assign hist_shifted = (upd_hist << 1) | K'(upd_taken);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int h = 0; h < HREGS; h++) begin
                hist_q[h] <= '0;
            end
        end else if (upd_valid) begin
            for (int h = 0; h < HREGS; h++) begin
                if (SEL_W'(h) == upd_sel) begin
                    hist_q[h] <= hist_shifted;
                end
            end
        end
    end

    generate
        for (genvar h = 0; h < HREGS; h++) begin : g_flat
            assign hist_vec[h*K +: K] = hist_q[h];
        end
    endgenerate

endmodule

// File: rtl/bp_index_gen.sv
module bp_index_gen #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned K     = 2,
    parameter int unsigned M     = 4,
    parameter bit          HASH  = 1'b0,
    localparam int unsigned IDX_W = M + K
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [K-1:0]     hist,
    output logic [IDX_W-1:0] idx
);
    import bp_corr_pkg::*;

    generate
        if (HASH) begin : g_hash
            // Wide PC slice folded with the history.
            assign idx = pc[PC_ALIGN_BITS +: IDX_W] ^ IDX_W'(hist);
        end else begin : g_concat
            // Address bits on top, history below.
            assign idx = {pc[PC_ALIGN_BITS +: M], hist};
        end
    endgenerate

endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned N     = 2,
    localparam int unsigned ENT     = 1 << IDX_W,
    localparam logic [N-1:0] CTR_MAX = {N{1'b1}},
    localparam logic [N-1:0] CTR_WNT = CTR_MAX >> 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic               upd_valid,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic               upd_taken,
    output logic               lk_taken,
    output logic [ENT*N-1:0]   ctr_vec
);
    import bp_corr_pkg::*;

    logic [N-1:0] ctr_q [ENT];
    ctr_act_e     act   [ENT];
    logic [N-1:0] lk_ctr;

    // Transition chosen for each entry.
    always_comb begin
        for (int e = 0; e < ENT; e++) begin
            if (upd_valid && (IDX_W'(e) == upd_idx)) begin
                act[e] = upd_taken ? CTR_INC : CTR_DEC;
            end else begin
                act[e] = CTR_HOLD;
            end
        end
    end

    // State register of every counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENT; e++) begin
                ctr_q[e] <= CTR_WNT;
            end
        end else begin
            for (int e = 0; e < ENT; e++) begin
                unique case (act[e])
                    CTR_HOLD: ctr_q[e] <= ctr_q[e];
                    CTR_INC: begin
                        if (ctr_q[e] != CTR_MAX) ctr_q[e] <= ctr_q[e] + N'(1);
                    end
                    CTR_DEC: begin
                        if (ctr_q[e] != '0) ctr_q[e] <= ctr_q[e] - N'(1);
                    end
                    default: ctr_q[e] <= ctr_q[e];
                endcase
            end
        end
    end

    // Output process: the upper half of the range predicts taken.
    always_comb begin
        lk_ctr   = ctr_q[lk_idx];
        lk_taken = lk_ctr[N-1];
    end

    generate
        for (genvar e = 0; e < ENT; e++) begin : g_flat
            assign ctr_vec[e*N +: N] = ctr_q[e];
        end
    endgenerate

endmodule

// File: rtl/bp_corr_predictor.sv
module bp_corr_predictor #(
    parameter int unsigned PC_W          = 32,
    parameter int unsigned HIST_BITS     = 2,
    parameter int unsigned HIST_SEL_BITS = 0,
    parameter int unsigned PAT_PC_BITS   = 4,
    parameter int unsigned CTR_BITS      = 2,
    parameter bit          HASH_IDX      = 1'b0,
    localparam int unsigned IDX_W = PAT_PC_BITS + HIST_BITS,
    localparam int unsigned ENT   = 1 << IDX_W,
    localparam int unsigned HREGS = 1 << HIST_SEL_BITS,
    localparam int unsigned SEL_W = (HIST_SEL_BITS > 0) ? HIST_SEL_BITS : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    logic [HIST_BITS-1:0]       lk_hist;
    logic [HIST_BITS-1:0]       upd_hist;
    logic [SEL_W-1:0]           upd_sel;
    logic [HREGS*HIST_BITS-1:0] hist_vec;
    logic [IDX_W-1:0]           lk_idx;
    logic [IDX_W-1:0]           upd_idx;
    logic [ENT*CTR_BITS-1:0]    ctr_vec;

    bp_hist_file #(
        .PC_W (PC_W),
        .K    (HIST_BITS),
        .A    (HIST_SEL_BITS)
    ) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken),
        .lk_hist   (lk_hist),
        .upd_hist  (upd_hist),
        .upd_sel   (upd_sel),
        .hist_vec  (hist_vec)
    );

    bp_index_gen #(
        .PC_W (PC_W),
        .K    (HIST_BITS),
        .M    (PAT_PC_BITS),
        .HASH (HASH_IDX)
    ) lk_ix_i (
        .pc   (lk_pc),
        .hist (lk_hist),
        .idx  (lk_idx)
    );

    bp_index_gen #(
        .PC_W (PC_W),
        .K    (HIST_BITS),
        .M    (PAT_PC_BITS),
        .HASH (HASH_IDX)
    ) upd_ix_i (
        .pc   (upd_pc),
        .hist (upd_hist),
        .idx  (upd_idx)
    );

    bp_pattern_table #(
        .IDX_W (IDX_W),
        .N     (CTR_BITS)
    ) pht_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx),
        .upd_taken (upd_taken),
        .lk_taken  (lk_taken),
        .ctr_vec   (ctr_vec)
    );

endmodule

// File: rtl/bp_corr_checker.sv
module bp_corr_checker #(
    parameter int unsigned K     = 2,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned N     = 2,
    parameter int unsigned HREGS = 1,
    parameter int unsigned SEL_W = 1,
    localparam int unsigned ENT  = 1 << IDX_W,
    localparam logic [N-1:0] CMAX = {N{1'b1}},
    localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}}
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic               upd_taken,
    input logic [SEL_W-1:0]   upd_sel,
    input logic [K-1:0]       upd_hist,
    input logic [IDX_W-1:0]   upd_idx,
    input logic [IDX_W-1:0]   lk_idx,
    input logic               lk_taken,
    input logic [HREGS*K-1:0] hist_vec,
    input logic [ENT*N-1:0]   ctr_vec
);

    logic [ENT*N-1:0] prev_ctr;
    logic             seen_q;
    logic [ENT-1:0]   chg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            prev_ctr <= '0;
        end else begin
            seen_q   <= 1'b1;
            prev_ctr <= ctr_vec;
        end
    end

    always_comb begin
        for (int e = 0; e < ENT; e++) begin
            chg[e] = ctr_vec[e*N +: N] != prev_ctr[e*N +: N];
        end
    end

    AST_PRED_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken == (ctr_vec[lk_idx*N +: N] >= HALF)); // R2

    AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && (ctr_vec[upd_idx*N +: N] != CMAX)) |=>
        (ctr_vec[$past(upd_idx)*N +: N] == $past(ctr_vec[upd_idx*N +: N]) + N'(1))); // R3

    AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && (ctr_vec[upd_idx*N +: N] != '0)) |=>
        (ctr_vec[$past(upd_idx)*N +: N] == $past(ctr_vec[upd_idx*N +: N]) - N'(1))); // R3

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && (ctr_vec[upd_idx*N +: N] == CMAX)) |=>
        (ctr_vec[$past(upd_idx)*N +: N] == CMAX)); // R3

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && (ctr_vec[upd_idx*N +: N] == '0)) |=>
        (ctr_vec[$past(upd_idx)*N +: N] == '0)); // R3

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=>
        (hist_vec[$past(upd_sel)*K +: K] ==
         (($past(upd_hist) << 1) | K'($past(upd_taken))))); // R4

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(hist_vec) && $stable(ctr_vec))); // R5

    AST_ONE_CTR_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ($countones(chg) <= 1)); // R5

endmodule

bind bp_corr_predictor bp_corr_checker #(
    .K     (HIST_BITS),
    .IDX_W (IDX_W),
    .N     (CTR_BITS),
    .HREGS (HREGS),
    .SEL_W (SEL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .upd_sel   (upd_sel),
    .upd_hist  (upd_hist),
    .upd_idx   (upd_idx),
    .lk_idx    (lk_idx),
    .lk_taken  (lk_taken),
    .hist_vec  (hist_vec),
    .ctr_vec   (ctr_vec)
);

// File: tb/bp_corr_predictor_tb.sv
module bp_corr_predictor_tb_top;

    localparam int unsigned PC_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic            pred_g;
    logic            pred_p;
    logic            pred_h;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // Global history, concatenated index: the (2,2) arrangement with 4 PC bits.
    bp_corr_predictor #(
        .PC_W(PC_W), .HIST_BITS(2), .HIST_SEL_BITS(0),
        .PAT_PC_BITS(4), .CTR_BITS(2), .HASH_IDX(1'b0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred_g),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // Per-address history: 4 history registers picked by PC[3:2], 2 PC bits in the index.
    bp_corr_predictor #(
        .PC_W(PC_W), .HIST_BITS(2), .HIST_SEL_BITS(2),
        .PAT_PC_BITS(2), .CTR_BITS(2), .HASH_IDX(1'b0)
    ) dut_pa_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred_p),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // Global history, hashed index PC[7:2] ^ history.
    bp_corr_predictor #(
        .PC_W(PC_W), .HIST_BITS(2), .HIST_SEL_BITS(0),
        .PAT_PC_BITS(4), .CTR_BITS(2), .HASH_IDX(1'b1)
    ) dut_hs_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred_h),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    typedef struct packed {
        logic [15:0] upc;
        logic        utk;
        logic [15:0] lpc;
        logic        exp;
    } vec_t;

    // Update, then look up with the history that update left behind (dut_i).
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0010, 1'b1, 16'h0010, 1'b0},  // idx10->2, hist 01, look idx11=1
        '{16'h0010, 1'b1, 16'h0010, 1'b0},  // idx11->2, hist 11, look idx13=1
        '{16'h0010, 1'b1, 16'h0010, 1'b1},  // idx13->2, look idx13
        '{16'h0010, 1'b1, 16'h0013, 1'b1},  // idx13->3, low PC bits ignored
        '{16'h0010, 1'b1, 16'h0010, 1'b1},  // idx13 stays 3
        '{16'h0010, 1'b0, 16'h0010, 1'b0},  // idx13->2, hist 10, look idx12=1
        '{16'h0020, 1'b1, 16'h0010, 1'b1},  // idx22->2, hist 01, look idx11=2
        '{16'h0024, 1'b1, 16'h0010, 1'b1},  // idx25->2, hist 11, look idx13=2
        '{16'h0010, 1'b0, 16'h0020, 1'b1},  // idx13->1, hist 10, look idx22=2
        '{16'h0044, 1'b0, 16'h0010, 1'b1},  // idx06->0, hist 00, look idx10=2
        '{16'h0010, 1'b1, 16'h0050, 1'b1}   // idx10->3, hist 01, 0x50 aliases: idx11=2
    };

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    task automatic do_reset();
        upd_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic do_update(input logic [PC_W-1:0] pc, input logic tk);
        upd_pc    = pc;
        upd_taken = tk;
        upd_valid = 1'b1;
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state predicts not-taken everywhere.
        do_reset();
        lk_pc = 16'h0000; #2;
        check(pred_g, 1'b0, "R1 global pc0000");
        check(pred_p, 1'b0, "R1 per-addr pc0000");
        check(pred_h, 1'b0, "R1 hashed pc0000");
        lk_pc = 16'hFFFC; #2;
        check(pred_g, 1'b0, "R1 global pcFFFC");
        check(pred_p, 1'b0, "R1 per-addr pcFFFC");
        check(pred_h, 1'b0, "R1 hashed pcFFFC");

        // Vector table: R2 threshold, R3 saturation, R4 history, R6 sharing, R8 index.
        for (int v = 0; v < NV; v++) begin
            do_update(VECS[v].upc, VECS[v].utk);
            lk_pc = VECS[v].lpc; #2;
            check(pred_g, VECS[v].exp, $sformatf("R2/R3/R4/R6/R8 vector %0d", v));
        end

        // R10: lookup while updating the same entry sees the old counter.
        do_reset();
        upd_pc = 16'h0010; upd_taken = 1'b1; upd_valid = 1'b1;
        lk_pc = 16'h0010; #2;
        check(pred_g, 1'b0, "R10 same-cycle lookup pre-update");
        @(posedge clk);
        #1 upd_valid = 1'b0;
        lk_pc = 16'h0010; #2;
        check(pred_g, 1'b0, "R10 after edge, history now 01");
        do_update(16'h0020, 1'b0);
        do_update(16'h0020, 1'b0);
        lk_pc = 16'h0010; #2;
        check(pred_g, 1'b1, "R10 update landed, R5 other updates left it");

        // R3: lower saturation, counter idx 8 stuck at 0.
        do_reset();
        do_update(16'h0008, 1'b0);
        do_update(16'h0008, 1'b0);
        do_update(16'h0008, 1'b0);
        do_update(16'h0008, 1'b1);
        do_update(16'h0030, 1'b0);
        do_update(16'h0030, 1'b0);
        lk_pc = 16'h0008; #2;
        check(pred_g, 1'b0, "R3 saturate at zero then one taken");
        do_update(16'h0008, 1'b1);
        do_update(16'h0030, 1'b0);
        do_update(16'h0030, 1'b0);
        lk_pc = 16'h0008; #2;
        check(pred_g, 1'b1, "R3 second taken crosses threshold");

        // R7: per-address histories are independent.
        do_reset();
        do_update(16'h0004, 1'b1);
        do_update(16'h0004, 1'b0);
        do_update(16'h0004, 1'b0);
        do_update(16'h0000, 1'b1);
        lk_pc = 16'h0004; #2;
        check(pred_p, 1'b1, "R7 pc0004 keeps own history 00");
        lk_pc = 16'h0014; #2;
        check(pred_p, 1'b1, "R7 pc0014 shares PC[3:2] with pc0004");
        lk_pc = 16'h0000; #2;
        check(pred_p, 1'b0, "R7 pc0000 history 01");

        // R9: hashed index.
        do_reset();
        do_update(16'h0004, 1'b1);
        lk_pc = 16'h0000; #2;
        check(pred_h, 1'b1, "R9 hashed 0^1 hits trained entry 1");
        check(pred_g, 1'b0, "R8 concat index differs for same pattern");
        lk_pc = 16'h0040; #2;
        check(pred_h, 1'b0, "R9 hashed upper PC bit changes index");
        lk_pc = 16'h0008; #2;
        check(pred_h, 1'b0, "R9 hashed 2^1 untrained");

        finished = 1'b1;
        report();
        $finish;
    end

endmodule